// File: doc/BRIEF.md
# Stacked-Die SDRAM Command Decoder and Bank-State Checker

This block sits beside a DDR4-style command/address bus and watches it on every rising clock edge. It turns chip select, the active-low activate strobe, the three shared row/column strobes, the address pins, bank group, bank address and stacked-die ID into one discrete command per cycle. For every one of the 128 banks (8 dies x 4 groups x 4 banks) it tracks whether a row is open and which row. It times a busy window after each column access and the gap between column accesses. Each cycle it reports the decoded command and an error code one clock later.

An activate is recognised by the strobe alone. The three command pins then act as the top three bits of an 18-bit row address. Column accesses may ask for auto-precharge or burst chop. A chopped burst moves only half the data, but it occupies its bank for the full burst time. Column accesses within one bank group must be spaced further apart than accesses that cross groups. A command that breaks a rule is flagged and otherwise dropped. It does not alter the tracked state.

Top module: `ddrcmd_monitor`

## Requirements
- R1: With `cs_n` high the cycle decodes as deselect (code 1), raises no error and changes no bank state, whatever the other pins carry.
- R2: With `cs_n` low and `act_n` low the cycle is an activate (code 2). The row is {`ras_n`,`cas_n`,`we_n`,`addr`} (18 bits). An accepted read or write later returns that row on `col_row`.
- R3: With `act_n` high, {`ras_n`,`cas_n`,`we_n`} decodes as: 111 no-op (0), 101 read (3), 100 write (4), 010 precharge (5, or 6 for all banks), 001 refresh (7), 000 mode-register set (8), 110 calibration (10), 011 reserved (9). Reserved raises error code 1.
- R4: A precharge with `addr[10]` low closes only the addressed bank. With `addr[10]` high it closes every bank of the addressed die.
- R5: A read or write with `addr[10]` high closes its bank by itself when the busy window ends, so an activate is accepted BURST_CLKS+1 cycles after the access.
- R6: A read or write with `addr[12]` high (burst chop) keeps its bank busy for the full BURST_CLKS cycles. Other banks stay usable during that time.
- R7: The bank index is {`cid`,`bg`,`ba`}, and all 128 banks hold independent state. A command to one die leaves the other dies unaffected.
- R8: A column command arriving less than TCCD_L cycles after the last accepted one in the same die and group gives error 6. One arriving less than TCCD_S cycles after the last accepted one elsewhere gives error 7.
- R9: An activate, read, write or single precharge to a bank that is within BURST_CLKS cycles of an accepted column access gives error 2. So does a precharge-all while any bank of that die is busy.
- R10: A read or write to a closed bank gives error 3. An activate to an open bank gives error 4.
- R11: A refresh or mode-register set while any bank of the addressed die is open gives error 5.
- R12: Error priority is 1, 2, then 3/4/5, then 6, then 7. A command with an error changes no state. `cmd_code`, `err_valid`, `err_code` and `col_row` appear one cycle after the command edge. After reset they read 1, 0, 0 and 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Chip select, active low |
| act_n | input | 1 | Activate strobe, active low |
| ras_n | input | 1 | Command pin / row bit 17 |
| cas_n | input | 1 | Command pin / row bit 16 |
| we_n | input | 1 | Command pin / row bit 15 |
| addr | input | ADDR_W | Address pins (bit 10 auto-precharge/all, bit 12 chop) |
| bg | input | BG_W | Bank group |
| ba | input | BA_W | Bank address |
| cid | input | CID_W | Stacked-die ID |
| cmd_code | output | 4 | Decoded command of the previous cycle |
| err_valid | output | 1 | Previous command broke a rule |
| err_code | output | 3 | Error class, 0 when none |
| col_row | output | ADDR_W+3 | Open row of an accepted column access, else 0 |

## Verification
Every result of a command sampled at edge N is registered once and is valid from edge N+1. The driver applies each command just after a falling edge and queues its expected outcome. The monitor pops that item at the next falling edge, half a period after the result settles. Busy, auto-precharge and spacing outcomes are due a fixed number of command slots after the access that started them. The bench places each probe in a counted slot (gap 2, 3, 4, 5 or 6 after the access) and checks the limit on both sides of each boundary.

// File: rtl/ddrcmd_pkg.sv
package ddrcmd_pkg;

   typedef enum logic [3:0] {
      CMD_NOP  = 4'd0,
      CMD_DES  = 4'd1,
      CMD_ACT  = 4'd2,
      CMD_RD   = 4'd3,
      CMD_WR   = 4'd4,
      CMD_PRE  = 4'd5,
      CMD_PREA = 4'd6,
      CMD_REF  = 4'd7,
      CMD_MRS  = 4'd8,
      CMD_RSVD = 4'd9,
      CMD_CAL  = 4'd10
   } cmd_e;

   typedef enum logic [2:0] {
      ERR_NONE     = 3'd0,
      ERR_ILLEGAL  = 3'd1,
      ERR_BUSY     = 3'd2,
      ERR_CLOSED   = 3'd3,
      ERR_OPEN     = 3'd4,
      ERR_DIE_BUSY = 3'd5,
      ERR_GAP_SAME = 3'd6,
      ERR_GAP_DIFF = 3'd7
   } err_e;

   localparam int BIT_AP = 10;  // auto-precharge / all-banks select
   localparam int BIT_BC = 12;  // burst chop request

   function automatic logic is_column(cmd_e c);
      return (c == CMD_RD) || (c == CMD_WR);
   endfunction

   function automatic logic hits_one_bank(cmd_e c);
      return (c == CMD_ACT) || (c == CMD_RD) || (c == CMD_WR) || (c == CMD_PRE);
   endfunction

endpackage

// File: rtl/ddrcmd_decode.sv
module ddrcmd_decode
   import ddrcmd_pkg::*;
#(
   parameter int ADDR_W = 15
) (
   input  logic              cs_n,
   input  logic              act_n,
   input  logic              ras_n,
   input  logic              cas_n,
   input  logic              we_n,
   input  logic              all_sel,
   output cmd_e              cmd
);

   always_comb begin
      if (cs_n) begin
         cmd = CMD_DES;
      end else if (!act_n) begin
         cmd = CMD_ACT;
      end else begin
         unique case ({ras_n, cas_n, we_n})
            3'b111:  cmd = CMD_NOP;
            3'b101:  cmd = CMD_RD;
            3'b100:  cmd = CMD_WR;
            3'b010:  cmd = all_sel ? CMD_PREA : CMD_PRE;
            3'b001:  cmd = CMD_REF;
            3'b000:  cmd = CMD_MRS;
            3'b110:  cmd = CMD_CAL;
            default: cmd = CMD_RSVD;
         endcase
      end
   end

endmodule

// File: rtl/ddrcmd_bank_table.sv
module ddrcmd_bank_table
   import ddrcmd_pkg::*;
#(
   parameter int IDX_W      = 7,
   parameter int CID_W      = 3,
   parameter int ROW_W      = 18,
   parameter int BURST_CLKS = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             accept,
   input  cmd_e             cmd,
   input  logic [IDX_W-1:0] idx,
   input  logic [ROW_W-1:0] row_in,
   input  logic             ap_req,
   output logic             sel_open,
   output logic             sel_busy,
   output logic [ROW_W-1:0] sel_row,
   output logic             die_open,
   output logic             die_busy
);

   localparam int NB      = 1 << IDX_W;
   localparam int NDIE    = 1 << CID_W;
   localparam int PER_DIE = NB / NDIE;
   localparam int BW      = $clog2(BURST_CLKS + 1);

   logic [NB-1:0]    open_v;
   logic [NB-1:0]    busy_v;
   logic [ROW_W-1:0] row_v [NB];
   logic [NDIE-1:0]  die_open_v;
   logic [NDIE-1:0]  die_busy_v;

   wire [CID_W-1:0] die_sel = idx[IDX_W-1 -: CID_W];

   for (genvar b = 0; b < NB; b++) begin : g_bank
      logic             open_b;
      logic             ap_b;
      logic [BW-1:0]    busy_b;
      logic [ROW_W-1:0] row_b;
      wire              hit     = (idx == IDX_W'(b));
      wire              die_hit = (die_sel == CID_W'(b / PER_DIE));

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            open_b <= 1'b0;
            ap_b   <= 1'b0;
            busy_b <= '0;
            row_b  <= '0;
         end else begin
            if (busy_b != '0) begin
               busy_b <= busy_b - 1'b1;
               if (busy_b == BW'(1) && ap_b) begin
                  open_b <= 1'b0;
                  ap_b   <= 1'b0;
               end
            end
            if (accept && hit) begin
               case (cmd)
                  CMD_ACT: begin
                     open_b <= 1'b1;
                     row_b  <= row_in;
                  end
                  CMD_RD, CMD_WR: begin
                     busy_b <= BW'(BURST_CLKS);
                     ap_b   <= ap_req;
                  end
                  CMD_PRE: open_b <= 1'b0;
                  default: ;
               endcase
            end
            if (accept && cmd == CMD_PREA && die_hit)
               open_b <= 1'b0;
         end
      end

      assign open_v[b] = open_b;
      assign busy_v[b] = (busy_b != '0);
      assign row_v[b]  = row_b;
   end

   for (genvar d = 0; d < NDIE; d++) begin : g_die
      assign die_open_v[d] = |open_v[d*PER_DIE +: PER_DIE];
      assign die_busy_v[d] = |busy_v[d*PER_DIE +: PER_DIE];
   end

   assign sel_open = open_v[idx];
   assign sel_busy = busy_v[idx];
   assign sel_row  = row_v[idx];
   assign die_open = die_open_v[die_sel];
   assign die_busy = die_busy_v[die_sel];

endmodule

// File: rtl/ddrcmd_col_spacing.sv
module ddrcmd_col_spacing #(
   parameter int BG_W   = 2,
   parameter int CID_W  = 3,
   parameter int TCCD_S = 4,
   parameter int TCCD_L = 6
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             col_cmd,
   input  logic             col_accept,
   input  logic [BG_W-1:0]  bg,
   input  logic [CID_W-1:0] cid,
   output logic             gap_same_bad,
   output logic             gap_diff_bad
);

   localparam int CW = $clog2(TCCD_L + 1);

   logic [CW-1:0]    since_q;
   logic [BG_W-1:0]  last_bg;
   logic [CID_W-1:0] last_cid;

   wire same_grp = (bg == last_bg) && (cid == last_cid);

   // gap in cycles equals since_q + 1
   assign gap_same_bad = col_cmd &&  same_grp && (since_q < CW'(TCCD_L - 1));
   assign gap_diff_bad = col_cmd && !same_grp && (since_q < CW'(TCCD_S - 1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         since_q  <= CW'(TCCD_L);
         last_bg  <= '0;
         last_cid <= '0;
      end else if (col_accept) begin
         since_q  <= '0;
         last_bg  <= bg;
         last_cid <= cid;
      end else if (since_q < CW'(TCCD_L)) begin
         since_q  <= since_q + 1'b1;
      end
   end

endmodule

// File: rtl/ddrcmd_monitor.sv
module ddrcmd_monitor
   import ddrcmd_pkg::*;
#(
   parameter int ADDR_W     = 15,
   parameter int BG_W       = 2,
   parameter int BA_W       = 2,
   parameter int CID_W      = 3,
   parameter int TCCD_S     = 4,
   parameter int TCCD_L     = 6,
   parameter int BURST_CLKS = 4
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                cs_n,
   input  logic                act_n,
   input  logic                ras_n,
   input  logic                cas_n,
   input  logic                we_n,
   input  logic [ADDR_W-1:0]   addr,
   input  logic [BG_W-1:0]     bg,
   input  logic [BA_W-1:0]     ba,
   input  logic [CID_W-1:0]    cid,
   output logic [3:0]          cmd_code,
   output logic                err_valid,
   output logic [2:0]          err_code,
   output logic [ADDR_W+2:0]   col_row
);

   localparam int ROW_W = ADDR_W + 3;
   localparam int IDX_W = CID_W + BG_W + BA_W;

   if (ADDR_W < BIT_BC + 1) begin : g_bad_addr
      $error("ADDR_W too narrow for the chop and auto-precharge bits");
   end
   if (TCCD_S < 1 || TCCD_L < TCCD_S) begin : g_bad_gap
      $error("column spacings must satisfy 1 <= TCCD_S <= TCCD_L");
   end
   if (BURST_CLKS < 1) begin : g_bad_burst
      $error("BURST_CLKS must be at least 1");
   end

   cmd_e             cmd;
   err_e             err_d;
   logic             accept;
   logic             sel_open, sel_busy, die_open, die_busy;
   logic [ROW_W-1:0] sel_row;
   logic             gap_same_bad, gap_diff_bad;

   wire [IDX_W-1:0] bank_idx = {cid, bg, ba};
   wire [ROW_W-1:0] act_row  = {ras_n, cas_n, we_n, addr};
   wire             col_now  = is_column(cmd);

   ddrcmd_decode #(.ADDR_W(ADDR_W)) u_dec (
      .cs_n    (cs_n),
      .act_n   (act_n),
      .ras_n   (ras_n),
      .cas_n   (cas_n),
      .we_n    (we_n),
      .all_sel (addr[BIT_AP]),
      .cmd     (cmd)
   );

   ddrcmd_bank_table #(
      .IDX_W(IDX_W), .CID_W(CID_W), .ROW_W(ROW_W), .BURST_CLKS(BURST_CLKS)
   ) u_tbl (
      .clk      (clk),
      .rst_n    (rst_n),
      .accept   (accept),
      .cmd      (cmd),
      .idx      (bank_idx),
      .row_in   (act_row),
      .ap_req   (addr[BIT_AP]),
      .sel_open (sel_open),
      .sel_busy (sel_busy),
      .sel_row  (sel_row),
      .die_open (die_open),
      .die_busy (die_busy)
   );

   ddrcmd_col_spacing #(
      .BG_W(BG_W), .CID_W(CID_W), .TCCD_S(TCCD_S), .TCCD_L(TCCD_L)
   ) u_gap (
      .clk          (clk),
      .rst_n        (rst_n),
      .col_cmd      (col_now),
      .col_accept   (col_now && accept),
      .bg           (bg),
      .cid          (cid),
      .gap_same_bad (gap_same_bad),
      .gap_diff_bad (gap_diff_bad)
   );

   always_comb begin
      err_d = ERR_NONE;
      if (cmd == CMD_RSVD)
         err_d = ERR_ILLEGAL;
      else if (hits_one_bank(cmd) && sel_busy)
         err_d = ERR_BUSY;
      else if (cmd == CMD_PREA && die_busy)
         err_d = ERR_BUSY;
      else if (col_now && !sel_open)
         err_d = ERR_CLOSED;
      else if (cmd == CMD_ACT && sel_open)
         err_d = ERR_OPEN;
      else if ((cmd == CMD_REF || cmd == CMD_MRS) && die_open)
         err_d = ERR_DIE_BUSY;
      else if (gap_same_bad)
         err_d = ERR_GAP_SAME;
      else if (gap_diff_bad)
         err_d = ERR_GAP_DIFF;
   end

   assign accept = (err_d == ERR_NONE) && (cmd != CMD_DES);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cmd_code  <= CMD_DES;
         err_valid <= 1'b0;
         err_code  <= ERR_NONE;
         col_row   <= '0;
      end else begin
         cmd_code  <= cmd;
         err_valid <= (err_d != ERR_NONE);
         err_code  <= err_d;
         col_row   <= (accept && col_now) ? sel_row : '0;
      end
   end

endmodule

// File: rtl/ddrcmd_monitor_chk.sv
module ddrcmd_monitor_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       cs_n,
   input logic       act_n,
   input logic       ras_n,
   input logic       cas_n,
   input logic       we_n,
   input logic [3:0] cmd_now,
   input logic       sel_busy,
   input logic       die_open,
   input logic [3:0] cmd_code,
   input logic       err_valid,
   input logic [2:0] err_code
);

   wire bank_cmd = (cmd_now == 4'd2) || (cmd_now == 4'd3) ||
                   (cmd_now == 4'd4) || (cmd_now == 4'd5);
   wire idle_cmd = (cmd_now == 4'd7) || (cmd_now == 4'd8);

   AST_DESELECT_INERT: assert property (@(posedge clk) disable iff (!rst_n)
      cs_n |=> (cmd_code == 4'd1 && !err_valid)); // R1

   AST_ACTIVATE_DECODED: assert property (@(posedge clk) disable iff (!rst_n)
      (!cs_n && !act_n) |=> (cmd_code == 4'd2)); // R2

   AST_RESERVED_FLAGGED: assert property (@(posedge clk) disable iff (!rst_n)
      (!cs_n && act_n && !ras_n && cas_n && we_n) |=> (err_valid && err_code == 3'd1)); // R3

   AST_BUSY_BANK_REJECTED: assert property (@(posedge clk) disable iff (!rst_n)
      (bank_cmd && sel_busy) |=> (err_code == 3'd2)); // R9

   AST_DIE_NOT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      (idle_cmd && die_open) |=> (err_code == 3'd5)); // R11

endmodule

bind ddrcmd_monitor ddrcmd_monitor_chk u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .cs_n      (cs_n),
   .act_n     (act_n),
   .ras_n     (ras_n),
   .cas_n     (cas_n),
   .we_n      (we_n),
   .cmd_now   (cmd),
   .sel_busy  (sel_busy),
   .die_open  (die_open),
   .cmd_code  (cmd_code),
   .err_valid (err_valid),
   .err_code  (err_code)
);

// File: tb/sim_ddrcmd_monitor.sv
module sim_ddrcmd_monitor;

   localparam logic [3:0] C_NOP = 4'd0, C_DES = 4'd1, C_ACT = 4'd2, C_RD = 4'd3,
                          C_WR = 4'd4, C_PRE = 4'd5, C_PREA = 4'd6, C_REF = 4'd7,
                          C_MRS = 4'd8, C_RSVD = 4'd9, C_CAL = 4'd10;
   localparam logic [2:0] E_OK = 3'd0, E_ILL = 3'd1, E_BUSY = 3'd2, E_CLOSED = 3'd3,
                          E_OPEN = 3'd4, E_DIE = 3'd5, E_GAPS = 3'd6, E_GAPD = 3'd7;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cs_n = 1'b1, act_n = 1'b1, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1;
   logic [14:0] addr = '0;
   logic [1:0]  bg = '0, ba = '0;
   logic [2:0]  cid = '0;
   logic [3:0]  cmd_code;
   logic        err_valid;
   logic [2:0]  err_code;
   logic [17:0] col_row;

   int checks = 0;
   int errors = 0;
   bit finished = 1'b0;

   typedef struct {
      logic [3:0]  cmd;
      logic [2:0]  err;
      logic [17:0] row;
      string       tag;
   } exp_t;

   exp_t sb[$];

   always #2 clk = ~clk;

   ddrcmd_monitor u0 (
      .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .act_n(act_n), .ras_n(ras_n),
      .cas_n(cas_n), .we_n(we_n), .addr(addr), .bg(bg), .ba(ba), .cid(cid),
      .cmd_code(cmd_code), .err_valid(err_valid), .err_code(err_code), .col_row(col_row)
   );

   task automatic report;
      if (!finished) begin
         finished = 1'b1;
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   endtask

   task automatic drive(input logic c_s, input logic a_s, input logic r, input logic ca,
                        input logic w, input logic [14:0] a, input logic [1:0] g,
                        input logic [1:0] b, input logic [2:0] d, input logic [3:0] ecmd,
                        input logic [2:0] eerr, input logic [17:0] erow, input string tag);
      exp_t e;
      @(negedge clk);
      #1;
      cs_n = c_s; act_n = a_s; ras_n = r; cas_n = ca; we_n = w;
      addr = a; bg = g; ba = b; cid = d;
      e.cmd = ecmd; e.err = eerr; e.row = erow; e.tag = tag;
      sb.push_back(e);
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++)
         drive(1, 1, 1, 1, 1, '0, '0, '0, '0, C_DES, E_OK, '0, "R1 idle");
   endtask

   task automatic act(input logic [2:0] d, input logic [1:0] g, input logic [1:0] b,
                      input logic [17:0] row, input logic [2:0] eerr, input string tag);
      drive(0, 0, row[17], row[16], row[15], row[14:0], g, b, d, C_ACT, eerr, '0, tag);
   endtask

   task automatic col(input logic wr, input logic [2:0] d, input logic [1:0] g,
                      input logic [1:0] b, input logic ap, input logic bc,
                      input logic [2:0] eerr, input logic [17:0] erow, input string tag);
      logic [14:0] a;
      a = 15'h0005;
      a[10] = ap;
      a[12] = bc;
      drive(0, 1, 1, 0, ~wr, a, g, b, d, wr ? C_WR : C_RD, eerr, erow, tag);
   endtask

   task automatic pre(input logic all, input logic [2:0] d, input logic [1:0] g,
                      input logic [1:0] b, input logic [2:0] eerr, input string tag);
      logic [14:0] a;
      a = '0;
      a[10] = all;
      drive(0, 1, 0, 1, 0, a, g, b, d, all ? C_PREA : C_PRE, eerr, '0, tag);
   endtask

   task automatic rcw(input logic r, input logic ca, input logic w, input logic [2:0] d,
                      input logic [3:0] ecmd, input logic [2:0] eerr, input string tag);
      drive(0, 1, r, ca, w, '0, '0, '0, d, ecmd, eerr, '0, tag);
   endtask

   // monitor: result of the command applied after negedge N is checked at negedge N+1
   initial begin
      exp_t e;
      @(posedge rst_n);
      forever begin
         @(negedge clk);
         if (sb.size() > 0) begin
            e = sb.pop_front();
            checks++;
            if (cmd_code !== e.cmd || err_code !== e.err || err_valid !== (e.err != 3'd0)
                || col_row !== e.row) begin
               errors++;
               $display("FAIL %s: got cmd=%0d err=%0d/%0b row=%h, expected cmd=%0d err=%0d row=%h",
                        e.tag, cmd_code, err_code, err_valid, col_row, e.cmd, e.err, e.row);
            end
         end
      end
   end

   initial begin
      #(4 * 20000);
      errors++;
      $display("FAIL watchdog: run did not complete, expected completion");
      report();
   end

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      checks++;
      if (cmd_code !== C_DES || err_valid !== 1'b0 || err_code !== E_OK || col_row !== '0) begin
         errors++;
         $display("FAIL R12 reset: got cmd=%0d err=%0d/%0b row=%h, expected 1 0/0 0",
                  cmd_code, err_code, err_valid, col_row);
      end
      rst_n = 1'b1;
      idle(1);
      col(0, 0, 0, 0, 0, 0, E_CLOSED, '0, "R10 read closed");
      act(0, 0, 0, 18'h2A5C3, E_OK, "R2 activate");
      act(0, 0, 0, 18'h00001, E_OPEN, "R10 activate open");
      idle(3);
      col(0, 0, 0, 0, 0, 1, E_OK, 18'h2A5C3, "R12 row kept after rejected act");  // t
      act(0, 1, 0, 18'h00111, E_OK, "R6 other bank during chop");                // t+1
      pre(0, 0, 0, 0, E_BUSY, "R6 chop keeps bank busy");                       // t+2
      idle(1);
      col(0, 0, 1, 0, 0, 0, E_OK, 18'h00111, "R8 cross-group gap 4");            // u
      col(0, 0, 1, 0, 0, 0, E_BUSY, '0, "R9 busy before spacing");               // u+1
      idle(1);
      col(0, 0, 0, 0, 0, 0, E_GAPD, '0, "R8 cross-group gap 3");                 // u+3
      col(0, 0, 0, 0, 0, 0, E_OK, 18'h2A5C3, "R8 cross-group gap 4 accepted");   // v
      idle(4);
      col(1, 0, 0, 0, 0, 0, E_GAPS, '0, "R8 same-group gap 5");                  // v+5
      col(1, 0, 0, 0, 1, 0, E_OK, 18'h2A5C3, "R5 write with auto-precharge");    // w
      idle(3);
      act(0, 0, 0, 18'h3FFFF, E_BUSY, "R9 activate busy bank");                 // w+4
      act(0, 0, 0, 18'h3FFFF, E_OK, "R5 bank closed by auto-precharge");         // w+5
      rcw(0, 0, 0, 0, C_MRS, E_DIE, "R11 mode set with open bank");
      rcw(0, 0, 1, 1, C_REF, E_OK, "R7 refresh on idle die");
      pre(1, 0, 0, 0, E_OK, "R4 precharge all");
      rcw(0, 0, 1, 0, C_REF, E_OK, "R11 refresh after all closed");
      col(0, 0, 1, 0, 0, 0, E_CLOSED, '0, "R4 all closed group 1");
      col(0, 0, 0, 0, 0, 0, E_CLOSED, '0, "R4 all closed group 0");
      act(2, 3, 3, 18'h00005, E_OK, "R7 die 2 bank 15");
      act(2, 3, 2, 18'h00006, E_OK, "R7 die 2 bank 14");
      pre(0, 2, 3, 3, E_OK, "R4 single precharge");
      col(0, 2, 3, 3, 0, 0, E_CLOSED, '0, "R4 target closed");
      col(1, 2, 3, 2, 0, 0, E_OK, 18'h00006, "R4 neighbour still open");        // x
      rcw(0, 1, 1, 0, C_RSVD, E_ILL, "R3 reserved");
      rcw(1, 1, 1, 0, C_NOP, E_OK, "R3 no-op");
      rcw(1, 1, 0, 0, C_CAL, E_OK, "R3 calibration");
      drive(1, 0, 0, 0, 0, 15'h7FFF, 2'd0, 2'd0, 3'd2, C_DES, E_OK, '0, "R1 deselect with act pins");
      col(0, 2, 0, 0, 0, 0, E_CLOSED, '0, "R1 deselected act ignored");
      act(7, 0, 0, 18'h00007, E_OK, "R7 die 7");
      col(0, 2, 3, 2, 0, 0, E_OK, 18'h00006, "R12 same group gap 7");            // y
      col(0, 7, 0, 0, 0, 0, E_GAPD, '0, "R8 other die gap 1");
      idle(2);
      col(0, 7, 0, 0, 0, 0, E_OK, 18'h00007, "R7 die 7 row");                   // y+4
      idle(2);
      wait (sb.size() == 0);
      @(negedge clk);
      report();
   end

endmodule